// File: doc/BRIEF.md
# Reset Sequencer with Watchdog Lock

This block merges every reset source of a chip into one ordered sequence, all timed on the slow 32 kHz clock. It has four inputs to merge. Two are power-on detectors: a coarse one and a precision one. The third is an external reset pin. The fourth is a watchdog expiry strobe.

The block drives several outputs from that sequence:
- the chip-wide device reset;
- the CPU reset;
- the power-down control of the main internal oscillator;
- the watchdog counter clear;
- two reset lines for trim registers. One line comes from the coarse detector only; the other comes from either detector.

A hard reset is a power-on event or an external pin reset. After a hard reset, the CPU stays in reset for a parameterised number of slow cycles. This gives the oscillator time to start.

Watchdog resets are gated by a one-way enable latch. Software sets the latch by writing 0 to the cold-start status bit. Only a hard reset clears the latch again. A watchdog reset runs a short fixed sequence:
- the device reset pulses for one cycle;
- the CPU reset is held for one more cycle;
- the oscillator keeps running;
- the watchdog counter is left untouched.

Two sticky status bits record the last reset cause, cold start or watchdog.

Top module: `rst_seq_top`

## Requirements
- R1: The power-on condition is the OR of `por_coarse_i` and `por_fine_i`. While it is high, `dev_rst_o`, `cpu_rst_o` and `wdt_clr_o` are high in the same cycle, with no clock edge needed.
- R2: `osc_pd_o` is high exactly while the power-on condition is high. It is low during external-pin resets and during watchdog resets.
- R3: `bg_trim_rst_o` follows `por_coarse_i` alone, and a precision-only power-on event leaves it low. `trim_rst_o` follows the power-on condition.
- R4: `ext_rst_i` passes through a synchroniser of SYNC_STAGES flops (default 2). With the default, `dev_rst_o` rises on the third rising edge after `ext_rst_i` goes high. It falls on the third rising edge after `ext_rst_i` goes low.
- R5: After a hard reset ends (`dev_rst_o` falls), `cpu_rst_o` falls exactly START_CYCLES rising edges later (default 4).
- R6: While the CPU is out of reset, a write (`ctrl_wr_i`=1) with `ctrl_cold_wdata_i`=0 sets `wdt_en_o` and clears `stat_cold_o` at the next edge. A write with data 1 changes neither bit. Writes made while `cpu_rst_o` is high are ignored.
- R7: Once `wdt_en_o` is set, no write clears it. Only a hard reset clears it.
- R8: A hard reset clears `wdt_en_o` and `stat_wdt_o`, sets `stat_cold_o`, and holds `wdt_clr_o` high while the reset is in progress.
- R9: A `wdt_expire_i` pulse that arrives while `wdt_en_o`=1 and the CPU is running has this effect. At the next edge, `dev_rst_o` goes high for exactly one cycle and `cpu_rst_o` goes high for exactly two cycles. Expiry with `wdt_en_o`=0 is ignored, and so is expiry during a watchdog sequence.
- R10: A watchdog reset sets `stat_wdt_o`. It leaves `stat_cold_o` and `wdt_en_o` unchanged and keeps `wdt_clr_o` and `osc_pd_o` low.
- R11: A hard reset that arrives during a watchdog sequence takes priority. The block then runs the full hard-reset sequence, including the START_CYCLES wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow 32 kHz sequencing clock |
| por_coarse_i | input | 1 | Coarse power-on detector output |
| por_fine_i | input | 1 | Precision power-on detector output |
| ext_rst_i | input | 1 | External reset pin, asynchronous |
| wdt_expire_i | input | 1 | Watchdog counter expiry strobe |
| ctrl_wr_i | input | 1 | Write strobe to the cold-start status bit |
| ctrl_cold_wdata_i | input | 1 | Write data; 0 arms the watchdog |
| dev_rst_o | output | 1 | Chip-wide device reset |
| cpu_rst_o | output | 1 | CPU reset |
| osc_pd_o | output | 1 | Main oscillator power-down |
| bg_trim_rst_o | output | 1 | Bandgap trim register reset |
| trim_rst_o | output | 1 | Reset for the other trim registers |
| wdt_clr_o | output | 1 | Watchdog counter clear |
| wdt_en_o | output | 1 | Watchdog reset enable latch |
| stat_cold_o | output | 1 | Cold-start status bit |
| stat_wdt_o | output | 1 | Watchdog-reset status bit |

## Verification
Outputs driven by the detectors (oscillator power-down, trim resets, and the forced levels of the device, CPU and clear resets) are due in the same cycle as the detector input. Registered results are due one edge after the input is sampled. The external pin takes SYNC_STAGES+1 edges. The CPU release comes START_CYCLES edges after the device reset falls.

The bench drives inputs shortly after each falling edge. It runs a cycle-level reference model on each rising edge and compares every output at the following falling edge. Each expected value is therefore taken after all the registers on its path have settled. Directed counts of the CPU hold time, the watchdog pulse widths and the synchroniser delay are measured in whole cycles from the stimulus.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_HARD     = 3'd0,
    ST_OSC_WAIT = 3'd1,
    ST_RUN      = 3'd2,
    ST_WD_PULSE = 3'd3,
    ST_WD_HOLD  = 3'd4
  } seq_state_t;

endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (clr) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int START_CYCLES = 4
) (
  input  logic clk,
  input  logic por_i,
  input  logic xres_i,
  input  logic wd_fire_i,
  output logic dev_rst_q,
  output logic cpu_rst_q,
  output logic wdt_clr_q,
  output logic run_o,
  output logic wd_evt_o
);

  localparam int CNT_W = (START_CYCLES > 1) ? $clog2(START_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_CYCLES - 1);

  seq_state_t       state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign run_o    = (state == ST_RUN);
  assign wd_evt_o = run_o && wd_fire_i && !xres_i;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    if (xres_i) begin
      nxt = ST_HARD;
    end else begin
      case (state)
        ST_HARD: begin
          nxt     = ST_OSC_WAIT;
          cnt_nxt = '0;
        end
        ST_OSC_WAIT: begin
          if (cnt == CNT_LAST) nxt = ST_RUN;
          else                 cnt_nxt = cnt + 1'b1;
        end
        ST_RUN:      if (wd_evt_o) nxt = ST_WD_PULSE;
        ST_WD_PULSE: nxt = ST_WD_HOLD;
        ST_WD_HOLD:  nxt = ST_RUN;
        default:     nxt = ST_HARD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      state     <= ST_HARD;
      cnt       <= '0;
      dev_rst_q <= 1'b1;
      cpu_rst_q <= 1'b1;
      wdt_clr_q <= 1'b1;
    end else begin
      state     <= nxt;
      cnt       <= cnt_nxt;
      dev_rst_q <= (nxt == ST_HARD) || (nxt == ST_WD_PULSE);
      cpu_rst_q <= (nxt != ST_RUN);
      wdt_clr_q <= (nxt == ST_HARD);
    end
  end

  // R9: one-cycle device pulse, two-cycle CPU hold
  a_r9_wd_shape: assert property (@(posedge clk) disable iff (por_i || xres_i)
    wd_evt_o |=> (dev_rst_q && cpu_rst_q) ##1 (!dev_rst_q && cpu_rst_q) ##1 !cpu_rst_q);

  // R5: CPU release never precedes device release
  a_r5_cpu_after_dev: assert property (@(posedge clk) disable iff (por_i || xres_i)
    $fell(cpu_rst_q) |-> (!dev_rst_q && $past(!dev_rst_q)));

  // R10: watchdog sequence leaves the counter clear low
  a_r10_no_clear: assert property (@(posedge clk) disable iff (por_i || xres_i)
    wd_evt_o |=> !wdt_clr_q);

endmodule

// File: rtl/wdt_lock.sv
module wdt_lock (
  input  logic clk,
  input  logic por_i,
  input  logic xres_i,
  input  logic run_i,
  input  logic wd_evt_i,
  input  logic wr_i,
  input  logic wdata_i,
  output logic en_q,
  output logic cold_q,
  output logic wdrs_q
);

  logic hard;
  assign hard = por_i || xres_i;

  always_ff @(posedge clk) begin
    if (hard) begin
      en_q   <= 1'b0;
      cold_q <= 1'b1;
      wdrs_q <= 1'b0;
    end else if (wd_evt_i) begin
      wdrs_q <= 1'b1;
    end else if (wr_i && run_i && !wdata_i) begin
      en_q   <= 1'b1;
      cold_q <= 1'b0;
    end
  end

  // R7: enable is sticky outside hard reset
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (hard)
    en_q |=> en_q);

  // R10: watchdog reset keeps the cold-start bit
  a_r10_cold_kept: assert property (@(posedge clk) disable iff (hard)
    wd_evt_i |=> $stable(cold_q));

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
  parameter int START_CYCLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_coarse_i,
  input  logic por_fine_i,
  input  logic ext_rst_i,
  input  logic wdt_expire_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_cold_wdata_i,
  output logic dev_rst_o,
  output logic cpu_rst_o,
  output logic osc_pd_o,
  output logic bg_trim_rst_o,
  output logic trim_rst_o,
  output logic wdt_clr_o,
  output logic wdt_en_o,
  output logic stat_cold_o,
  output logic stat_wdt_o
);

  logic por_any, xres_s, run, wd_evt;
  logic dev_q, cpu_q, clr_q;

  assign por_any = por_coarse_i | por_fine_i;

  rst_sync #(.STAGES(SYNC_STAGES)) u_xsync (
    .clk (clk),
    .clr (por_any),
    .d   (ext_rst_i),
    .q   (xres_s)
  );

  rst_seq_fsm #(.START_CYCLES(START_CYCLES)) u_fsm (
    .clk       (clk),
    .por_i     (por_any),
    .xres_i    (xres_s),
    .wd_fire_i (wdt_expire_i && wdt_en_o),
    .dev_rst_q (dev_q),
    .cpu_rst_q (cpu_q),
    .wdt_clr_q (clr_q),
    .run_o     (run),
    .wd_evt_o  (wd_evt)
  );

  wdt_lock u_lock (
    .clk      (clk),
    .por_i    (por_any),
    .xres_i   (xres_s),
    .run_i    (run),
    .wd_evt_i (wd_evt),
    .wr_i     (ctrl_wr_i),
    .wdata_i  (ctrl_cold_wdata_i),
    .en_q     (wdt_en_o),
    .cold_q   (stat_cold_o),
    .wdrs_q   (stat_wdt_o)
  );

  assign dev_rst_o     = dev_q | por_any;
  assign cpu_rst_o     = cpu_q | por_any;
  assign wdt_clr_o     = clr_q | por_any;
  assign osc_pd_o      = por_any;
  assign bg_trim_rst_o = por_coarse_i;
  assign trim_rst_o    = por_any;

  // R1: power-on forces all resets at once
  a_r1_por_forces: assert property (@(posedge clk)
    (por_coarse_i || por_fine_i) |-> (dev_rst_o && cpu_rst_o && wdt_clr_o));

  // R2: oscillator keeps running through a watchdog reset
  a_r2_osc_on_wd: assert property (@(posedge clk) disable iff (por_any)
    wd_evt |=> !osc_pd_o);

endmodule

// File: tb/sim_rst_seq_top.sv
module sim_rst_seq_top;

  localparam int START = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic c_in = 1'b1, f_in = 1'b0, x_in = 1'b0, w_in = 1'b0, wr_in = 1'b0, wd_in = 1'b1;
  logic dev_rst_o, cpu_rst_o, osc_pd_o, bg_trim_rst_o, trim_rst_o, wdt_clr_o;
  logic wdt_en_o, stat_cold_o, stat_wdt_o;

  rst_seq_top #(.START_CYCLES(START), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_coarse_i(c_in), .por_fine_i(f_in), .ext_rst_i(x_in),
    .wdt_expire_i(w_in), .ctrl_wr_i(wr_in), .ctrl_cold_wdata_i(wd_in),
    .dev_rst_o(dev_rst_o), .cpu_rst_o(cpu_rst_o), .osc_pd_o(osc_pd_o),
    .bg_trim_rst_o(bg_trim_rst_o), .trim_rst_o(trim_rst_o), .wdt_clr_o(wdt_clr_o),
    .wdt_en_o(wdt_en_o), .stat_cold_o(stat_cold_o), .stat_wdt_o(stat_wdt_o)
  );

  int checks = 0, fails = 0;
  bit chk_on = 0, done = 0;

  // reference model: 0 hard, 1 wait, 2 run, 3 wd pulse, 4 wd hold
  int m_st = 0, m_cnt = 0;
  bit m_x1 = 0, m_x2 = 0, m_en = 0, m_cold = 1, m_wdrs = 0;

  always @(posedge clk) begin : model
    bit por, hard;
    por  = c_in | f_in;
    hard = por || m_x2;
    if (por) begin m_x1 = 0; m_x2 = 0; end
    else begin m_x2 = m_x1; m_x1 = x_in; end
    if (hard) begin
      m_st = 0; m_en = 0; m_cold = 1; m_wdrs = 0;
    end else begin
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1: if (m_cnt == START - 1) m_st = 2; else m_cnt++;
        2: if (w_in && m_en) begin m_st = 3; m_wdrs = 1; end
           else if (wr_in && !wd_in) begin m_en = 1; m_cold = 0; end
        3: m_st = 4;
        default: m_st = 2;
      endcase
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_dev();
    return (c_in | f_in) || m_st == 0 || m_st == 3;
  endfunction

  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R1 R4 R9 R11 dev_rst", dev_rst_o, exp_dev());
      chk("R1 R5 R9 R11 cpu_rst", cpu_rst_o, (c_in | f_in) || m_st != 2);
      chk("R1 R8 R10 wdt_clr", wdt_clr_o, (c_in | f_in) || m_st == 0);
      chk("R2 osc_pd", osc_pd_o, c_in | f_in);
      chk("R3 bg_trim_rst", bg_trim_rst_o, c_in);
      chk("R3 trim_rst", trim_rst_o, c_in | f_in);
      chk("R6 R7 R8 wdt_en", wdt_en_o, m_en);
      chk("R6 R8 R10 stat_cold", stat_cold_o, m_cold);
      chk("R8 R10 stat_wdt", stat_wdt_o, m_wdrs);
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  initial begin : stim
    int n;
    void'($urandom(32'd2024));
    cyc(2);
    chk_on = 1;
    cyc(1);
    chk("R8 reset cold bit", stat_cold_o, 1'b1);
    chk("R8 reset enable", wdt_en_o, 1'b0);
    // R3: precision-only power-on leaves bandgap trim alone
    c_in = 0; f_in = 1; cyc(1);
    chk("R3 fine only bg", bg_trim_rst_o, 1'b0);
    chk("R3 fine only trim", trim_rst_o, 1'b1);
    // R5: CPU hold after release
    f_in = 0;
    n = 0;
    do begin @(negedge clk); if (cpu_rst_o) n++; end while (cpu_rst_o && n < 100);
    #1;
    chk_int("R5 cpu hold cycles", n, START);
    // R9: expiry without enable is ignored
    w_in = 1; cyc(1); w_in = 0;
    chk("R9 disabled expiry", dev_rst_o, 1'b0);
    // R6: write 1 ignored, write 0 arms
    wr_in = 1; wd_in = 1; cyc(1); wr_in = 0;
    chk("R6 write one", wdt_en_o, 1'b0);
    wr_in = 1; wd_in = 0; cyc(1); wr_in = 0; wd_in = 1;
    chk("R6 write zero", wdt_en_o, 1'b1);
    // R9: watchdog pulse widths
    w_in = 1; cyc(1); w_in = 0;
    n = 0;
    chk("R9 dev first", dev_rst_o, 1'b1);
    cyc(1);
    chk("R9 dev second", dev_rst_o, 1'b0);
    chk("R9 cpu second", cpu_rst_o, 1'b1);
    cyc(1);
    chk("R9 cpu third", cpu_rst_o, 1'b0);
    chk("R10 enable kept", wdt_en_o, 1'b1);
    chk("R10 osc running", osc_pd_o, 1'b0);
    // R7: write 1 cannot disarm
    wr_in = 1; wd_in = 1; cyc(1); wr_in = 0;
    chk("R7 still armed", wdt_en_o, 1'b1);
    // R11: power-on during a watchdog sequence
    w_in = 1; cyc(1); w_in = 0;
    f_in = 1; cyc(2); f_in = 0;
    n = 0;
    do begin @(negedge clk); if (cpu_rst_o) n++; end while (cpu_rst_o && n < 100);
    #1;
    chk_int("R11 full restart", n, START);
    chk("R11 enable cleared", wdt_en_o, 1'b0);
    // R4: external pin latency
    x_in = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!dev_rst_o && n < 20);
    #1;
    chk_int("R4 assert latency", n, 3);
    cyc(3);
    chk("R4 osc during pin reset", osc_pd_o, 1'b0);
    x_in = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (dev_rst_o && n < 20);
    #1;
    chk_int("R4 release latency", n, 3);
    cyc(START + 2);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      c_in = ($urandom_range(0, 399) == 0);
      f_in = ($urandom_range(0, 299) == 0);
      if ($urandom_range(0, 79) == 0) x_in = ~x_in;
      else if (x_in && $urandom_range(0, 5) == 0) x_in = 0;
      w_in  = ($urandom_range(0, 14) == 0);
      wr_in = ($urandom_range(0, 9) == 0);
      wd_in = $urandom_range(0, 1);
      cyc(1);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog timeout actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule